// File: doc/BRIEF.md
# Parity-Checked Configuration Byte Bank

This block is a bank of byte-wide configuration registers behind a plain register-access port. It would typically sit behind the back end of a serial slave. It holds eighteen writable configuration bytes and one read-only status byte. Each configuration byte carries its own parity bit in bit 7, and the host supplies that bit. The byte is good when its eight bits together hold an even number of ones.

A scanner visits one stored byte per clock and never stops, whether or not the bank is being accessed. It checks all eight bits of the byte, including bits that downstream logic ignores. An odd count sets a sticky parity-error flag. The flag and an external error input together drive an active-low error output. The flag clears in only two ways: by reset, or by rewriting every configuration byte and then completing a full scan pass that finds no bad byte.

Only the low five bits of the access address are decoded, so every address above 0x1F aliases back into the 0x00 to 0x1F window. The raw configuration bytes are presented to downstream logic on one flat bus.

Top module: `cfg_parity_bank`

## Requirements
- R1: After reset, every configuration byte reads 0x00, cfg_flat is all zero, par_err is 0, and err_n is 1 while stat_err_in is 0.
- R2: A write with wr_en high to a decoded index from 0 to 17 stores all eight bits of wr_data, parity bit included, in that byte. From the next cycle the byte reads back on rd_data and appears on cfg_flat bits [8*i+7:8*i].
- R3: Only acc_addr[4:0] selects the register. The addresses a, a+0x20, a+0x40 and so on reach the same byte for both reads and writes.
- R4: Index 18 is the status byte. It holds bit 2 = par_err, bit 1 = stat_err_in, bit 0 = pos_ok_in, and bits 7:3 read as 0. Writes to index 18 change no configuration byte.
- R5: Indexes 19 to 31 read as 0x00, and writes to them change no configuration byte.
- R6: A configuration byte with an odd number of ones sets par_err within 19 cycles of the write that stored it. This covers a bad bit 7 and a bad unused bit alike.
- R7: par_err stays set after the bad byte alone is rewritten with good parity, for as long as some configuration byte has not been rewritten since the last bad byte was seen.
- R8: Once all 18 configuration bytes have been rewritten with even parity, par_err clears within 37 cycles after the last of those writes. It clears only after such a full rewrite.
- R9: err_n is low whenever par_err or stat_err_in is high, and high otherwise, with no added cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_addr | input | 8 | Access address; only bits 4:0 are decoded |
| wr_en | input | 1 | Write strobe for acc_addr |
| wr_data | input | 8 | Write byte, parity bit in bit 7 |
| rd_data | output | 8 | Byte at acc_addr, combinational |
| stat_err_in | input | 1 | External error condition |
| pos_ok_in | input | 1 | External position-valid indication |
| cfg_flat | output | 144 | All configuration bytes, byte i at [8*i+7:8*i] |
| par_err | output | 1 | Sticky parity-error flag |
| err_n | output | 1 | Active-low error output |

## Verification
Reads and err_n are combinational, so the bench samples them one time step after it changes the address or the inputs. A write lands at the clock edge that follows the strobe, and the bench reads it back at the next falling edge. A bad byte may wait up to 18 scan slots before the scanner reaches it, plus one register stage for the flag, so the bench looks at par_err 20 edges after the write. Clearing may first wait for the scan pointer to come round to index 0 and then needs a full 18-slot pass, so the bench waits 39 edges after the last rewrite, and it tests the sticky case over the same window.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
   // status byte field positions (decoded by the host side)
   localparam int STAT_POS_BIT  = 0;
   localparam int STAT_SERR_BIT = 1;
   localparam int STAT_PERR_BIT = 2;
   localparam int STAT_USED     = 3;
endpackage

// File: rtl/cfgb_store.sv
module cfgb_store #(
   parameter int NUM_CFG = 18,
   parameter int DATA_W  = 8,
   parameter int IDX_W   = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [DATA_W-1:0]         wr_data,
   output logic [NUM_CFG*DATA_W-1:0] cfg_flat,
   output logic [NUM_CFG-1:0]        wr_hit
);
   for (genvar i = 0; i < NUM_CFG; i++) begin : g_byte
      logic [DATA_W-1:0] q;
      assign wr_hit[i] = wr_en && (wr_idx == IDX_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         q <= '0;
         else if (wr_hit[i]) q <= wr_data;
      end
      assign cfg_flat[i*DATA_W +: DATA_W] = q;
   end
endmodule

// File: rtl/cfgb_scan.sv
module cfgb_scan #(
   parameter int NUM_CFG = 18,
   parameter int DATA_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CFG*DATA_W-1:0] cfg_flat,
   input  logic [NUM_CFG-1:0]        wr_hit,
   output logic                      par_err,
   output logic                      scan_odd,
   output logic                      all_rw
);
   localparam int PTR_W = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_CFG - 1);

   logic [PTR_W-1:0]   ptr;
   logic [NUM_CFG-1:0] rw_mask;
   logic               pass_act;
   logic               err_q;
   logic               at_first, at_last, pass_ok;

   assign scan_odd = ^cfg_flat[ptr*DATA_W +: DATA_W];
   assign at_first = (ptr == '0);
   assign at_last  = (ptr == LAST);
   assign all_rw   = &rw_mask;
   assign pass_ok  = at_first ? (all_rw && !scan_odd) : (pass_act && !scan_odd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr      <= '0;
         err_q    <= 1'b0;
         pass_act <= 1'b0;
         rw_mask  <= '0;
      end else begin
         ptr <= at_last ? '0 : ptr + 1'b1;
         if (scan_odd)                        err_q <= 1'b1;
         else if (err_q && at_last && pass_ok) err_q <= 1'b0;
         pass_act <= err_q && pass_ok && !at_last;
         if (scan_odd || !err_q) rw_mask <= '0;
         else                    rw_mask <= rw_mask | wr_hit;
      end
   end

   assign par_err = err_q;
endmodule

// File: rtl/cfgb_rdmux.sv
module cfgb_rdmux #(
   parameter int NUM_CFG = 18,
   parameter int DATA_W  = 8,
   parameter int IDX_W   = 5
) (
   input  logic [IDX_W-1:0]          rd_idx,
   input  logic [NUM_CFG*DATA_W-1:0] cfg_flat,
   input  logic [DATA_W-1:0]         stat_byte,
   output logic [DATA_W-1:0]         rd_data
);
   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_CFG; i++) begin
         if (rd_idx == IDX_W'(i)) rd_data = cfg_flat[i*DATA_W +: DATA_W];
      end
      if (rd_idx == IDX_W'(NUM_CFG)) rd_data = stat_byte;
   end
endmodule

// File: rtl/cfg_parity_bank.sv
module cfg_parity_bank #(
   parameter int NUM_CFG   = 18,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 5,
   parameter int IN_ADDR_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [IN_ADDR_W-1:0]      acc_addr,
   input  logic                      wr_en,
   input  logic [DATA_W-1:0]         wr_data,
   output logic [DATA_W-1:0]         rd_data,
   input  logic                      stat_err_in,
   input  logic                      pos_ok_in,
   output logic [NUM_CFG*DATA_W-1:0] cfg_flat,
   output logic                      par_err,
   output logic                      err_n
);
   import cfgb_pkg::*;

   if (NUM_CFG + 1 > (1 << ADDR_W)) begin : g_bad_depth
      $error("cfg_parity_bank: NUM_CFG plus status exceeds decoded space");
   end
   if (IN_ADDR_W < ADDR_W) begin : g_bad_addr
      $error("cfg_parity_bank: IN_ADDR_W narrower than ADDR_W");
   end
   if (DATA_W <= STAT_USED) begin : g_bad_width
      $error("cfg_parity_bank: DATA_W too small for status fields");
   end

   logic [ADDR_W-1:0]  idx;
   logic [NUM_CFG-1:0] wr_hit;
   logic [DATA_W-1:0]  stat_byte;
   logic               scan_odd;
   logic               all_rw;

   assign idx = acc_addr[ADDR_W-1:0];

   always_comb begin
      stat_byte                = '0;
      stat_byte[STAT_POS_BIT]  = pos_ok_in;
      stat_byte[STAT_SERR_BIT] = stat_err_in;
      stat_byte[STAT_PERR_BIT] = par_err;
   end

   cfgb_store #(.NUM_CFG(NUM_CFG), .DATA_W(DATA_W), .IDX_W(ADDR_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx),
      .wr_data(wr_data), .cfg_flat(cfg_flat), .wr_hit(wr_hit)
   );

   cfgb_scan #(.NUM_CFG(NUM_CFG), .DATA_W(DATA_W)) u_scan (
      .clk(clk), .rst_n(rst_n), .cfg_flat(cfg_flat), .wr_hit(wr_hit),
      .par_err(par_err), .scan_odd(scan_odd), .all_rw(all_rw)
   );

   cfgb_rdmux #(.NUM_CFG(NUM_CFG), .DATA_W(DATA_W), .IDX_W(ADDR_W)) u_rd (
      .rd_idx(idx), .cfg_flat(cfg_flat), .stat_byte(stat_byte), .rd_data(rd_data)
   );

   assign err_n = !(par_err || stat_err_in);
endmodule

// File: rtl/cfgb_chk.sv
module cfgb_chk #(
   parameter int NUM_CFG = 18,
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 5
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [ADDR_W-1:0]         idx,
   input logic                      wr_en,
   input logic [DATA_W-1:0]         rd_data,
   input logic                      stat_err_in,
   input logic [NUM_CFG*DATA_W-1:0] cfg_flat,
   input logic                      par_err,
   input logic                      err_n,
   input logic                      scan_odd,
   input logic                      all_rw
);
   localparam logic [ADDR_W-1:0] STAT_IDX = ADDR_W'(NUM_CFG);

   AST_ODD_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) scan_odd |=> par_err); // R6
   AST_RISE_NEEDS_ODD: assert property (@(posedge clk) disable iff (!rst_n) $rose(par_err) |-> $past(scan_odd)); // R6
   AST_FALL_NEEDS_REWRITE: assert property (@(posedge clk) disable iff (!rst_n) $fell(par_err) |-> $past(all_rw)); // R8
   AST_FLAG_DRIVES_OUT: assert property (@(posedge clk) disable iff (!rst_n) (par_err || stat_err_in) |-> !err_n); // R9
   AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (idx == STAT_IDX) |-> (rd_data[DATA_W-1:3] == '0)); // R4
   AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (idx > STAT_IDX) |-> (rd_data == '0)); // R5
   AST_HIGH_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && idx >= STAT_IDX) |=> $stable(cfg_flat)); // R5
endmodule

bind cfg_parity_bank cfgb_chk #(.NUM_CFG(NUM_CFG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .idx(idx), .wr_en(wr_en), .rd_data(rd_data),
   .stat_err_in(stat_err_in), .cfg_flat(cfg_flat), .par_err(par_err),
   .err_n(err_n), .scan_odd(scan_odd), .all_rw(all_rw)
);

// File: tb/sim_cfg_parity_bank.sv
`timescale 1ns/1ps
module sim_cfg_parity_bank;
   localparam int N = 18;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   acc_addr = '0;
   logic         wr_en = 1'b0;
   logic [7:0]   wr_data = '0;
   logic [7:0]   rd_data;
   logic         stat_err_in = 1'b0;
   logic         pos_ok_in = 1'b0;
   logic [N*8-1:0] cfg_flat;
   logic         par_err;
   logic         err_n;

   int checks = 0;
   int errors = 0;
   logic [7:0] model [N];

   always #2.5 clk = ~clk;

   cfg_parity_bank u0 (
      .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .stat_err_in(stat_err_in),
      .pos_ok_in(pos_ok_in), .cfg_flat(cfg_flat), .par_err(par_err), .err_n(err_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      acc_addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      if (a[4:0] < N) model[a[4:0]] = d;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      acc_addr = a;
      #1 d = rd_data;
   endtask

   task automatic wait_edges(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic cmp_model(input string req);
      logic [N*8-1:0] e;
      for (int i = 0; i < N; i++) e[i*8 +: 8] = model[i];
      checks++;
      if (cfg_flat !== e) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, cfg_flat, e);
      end
   endtask

   task automatic t_reset();
      logic [7:0] d;
      for (int i = 0; i < N; i++) model[i] = 8'h00;
      cmp_model("R1 cfg_flat");
      rd(8'h00, d); chk("R1 rd0", d, 8'h00);
      rd(8'h11, d); chk("R1 rd17", d, 8'h00);
      chk("R1 par_err", par_err, 0);
      chk("R1 err_n", err_n, 1);
   endtask

   task automatic t_write_read();
      logic [7:0] d;
      wr(8'h00, 8'hA5);
      wr(8'h11, 8'h81);
      wr(8'h09, 8'h3C);
      rd(8'h00, d); chk("R2 rd0", d, 8'hA5);
      rd(8'h11, d); chk("R2 rd17", d, 8'h81);
      rd(8'h09, d); chk("R2 rd9", d, 8'h3C);
      cmp_model("R2 cfg_flat");
   endtask

   task automatic t_alias();
      logic [7:0] d;
      wr(8'h25, 8'h03);
      rd(8'h05, d); chk("R3 alias write", d, 8'h03);
      rd(8'hE5, d); chk("R3 alias read", d, 8'h03);
      wr(8'hF1, 8'h90);
      rd(8'h11, d); chk("R3 alias high", d, 8'h90);
      cmp_model("R3 cfg_flat");
   endtask

   task automatic t_status_hole();
      logic [7:0] d;
      wr(8'h12, 8'hFF);
      wr(8'h13, 8'hFF);
      wr(8'h1F, 8'h77);
      wr(8'h32, 8'h55);
      cmp_model("R5 writes ignored");
      for (int a = 8'h13; a <= 8'h1F; a++) begin
         rd(8'(a), d); chk("R5 hole read", d, 8'h00);
      end
      stat_err_in = 1'b0; pos_ok_in = 1'b1;
      rd(8'h12, d); chk("R4 status pos", d, 8'h01);
      stat_err_in = 1'b1; pos_ok_in = 1'b0;
      rd(8'h52, d); chk("R4 status serr", d, 8'h02);
      chk("R9 ext err", err_n, 0);
      stat_err_in = 1'b0;
      #1 chk("R9 no err", err_n, 1);
   endtask

   task automatic t_bad_parity(input logic [7:0] a, input logic [7:0] bad, input string req);
      logic [7:0] d;
      wr(a, bad);
      wait_edges(N + 2);
      chk(req, par_err, 1);
      rd(8'h12, d); chk("R4 status perr", d, 8'h04);
      chk("R9 err_n low", err_n, 0);
   endtask

   task automatic t_sticky_clear();
      wr(8'h03, 8'h00);
      wait_edges(2 * N + 3);
      chk("R7 sticky", par_err, 1);
      for (int i = 0; i < N; i++) wr(8'(i), (i % 2) ? 8'h03 : 8'h00);
      wait_edges(2 * N + 3);
      chk("R8 cleared", par_err, 0);
      chk("R9 err_n high", err_n, 1);
      cmp_model("R8 cfg_flat");
   endtask

   initial begin
      for (int i = 0; i < 100000; i++) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", checks);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_read();
      t_alias();
      t_status_hole();
      t_bad_parity(8'h03, 8'h80, "R6 bad parity bit");
      t_sticky_clear();
      t_bad_parity(8'h11, 8'h40, "R6 bad unused bit");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule